// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block turns a 32-bit virtual address into the base address of a 4 KiB physical page and a set of access permissions. It holds a small table of translation entries arranged as sets of several ways. A lookup takes the virtual page number, which is the address shifted right by 12. It picks one set from the low bits of that page number and probes every way of that set at once. An entry matches when its stored page number equals the lookup page number and either the entry is global or its stored process identifier equals the current one.

The lookup path is purely combinational from the address and process identifier to the outputs. A single write port loads one entry per clock: the caller gives the way, the page number (whose low bits also choose the set), the process identifier, a global flag, the physical frame number and three permission bits. Table walking, fault signalling and invalidation bookkeeping are handled elsewhere.

Top module: `tlb_lookup`

## Requirements
- R1: The lookup page number is `vaddr_i[31:12]`. The set probed is that page number modulo (NUM_ENTRIES / NUM_WAYS), and the low 12 address bits never affect the result. An entry in the same set with a different page number does not hit.
- R2: A non-global entry hits when its page number equals the lookup page number and its stored process identifier equals `pid_i`.
- R3: An entry written with the global flag set hits on a page number match for any value of `pid_i`.
- R4: A non-global entry whose stored process identifier differs from `pid_i` does not hit, even when its page number matches.
- R5: On a hit, `paddr_o` equals the entry's frame number shifted left by 12. `rd_o`, `wr_o` and `ex_o` equal the stored read, write and execute bits. In the bench these bits are packed as {execute, write, read}.
- R6: When several ways of the probed set match, the lowest-numbered way supplies the outputs.
- R7: When no way matches, `hit_o` is 0 and `paddr_o`, `rd_o`, `wr_o` and `ex_o` are all 0.
- R8: An entry loaded through the write port is invisible before the rising clock edge with `wr_en_i` high and visible right after it. The write changes only the addressed way and set.
- R9: Reset clears every entry to all-zero fields. A cleared entry therefore hits a lookup of page 0 with `pid_i` = 0 and returns a zero address and no permissions. Page 0 with any other process identifier misses. Entries loaded before a reset are gone after it.
- R10: Writing a way and set that is already loaded replaces the old contents completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the write port |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the table |
| vaddr_i | input | 32 | Virtual address to translate |
| pid_i | input | PID_W | Current process identifier |
| wr_en_i | input | 1 | Load one entry at the next rising edge |
| wr_way_i | input | WAY_W | Way to load |
| wr_vpn_i | input | 20 | Page number of the entry; low bits select the set |
| wr_pid_i | input | PID_W | Process identifier stored in the entry |
| wr_global_i | input | 1 | Entry matches any process identifier |
| wr_pfn_i | input | 20 | Physical frame number |
| wr_rd_i | input | 1 | Read permission |
| wr_wr_i | input | 1 | Write permission |
| wr_ex_i | input | 1 | Execute permission |
| hit_o | output | 1 | A way matched |
| paddr_o | output | 32 | Physical page base address |
| rd_o | output | 1 | Read allowed |
| wr_o | output | 1 | Write allowed |
| ex_o | output | 1 | Execute allowed |

## Verification
The hardest case to reach is a set in which more than one way matches at the same time. Only a deliberate load of the same page number into several ways can produce it. The stimulus loads ways 2 and 3 of one set with the same page and process identifier but different frames and permissions. It then adds a global entry in way 1 of that set, so the winner moves down and the priority order is seen to change. Write timing is checked by holding the lookup on the entry being loaded across the clock edge. The lookup must miss before that edge and hit after it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int PFN_W      = 20;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PFN_W-1:0] pfn_t;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int PID_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  vpn_t             wr_vpn_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic             wr_global_i,
  input  pfn_t             wr_pfn_i,
  input  perm_t            wr_perm_i,
  input  logic [SET_W-1:0] lk_set_i,
  input  vpn_t             lk_vpn_i,
  input  logic [PID_W-1:0] lk_pid_i,
  output logic             match_o,
  output pfn_t             pfn_o,
  output perm_t            perm_o
);
  vpn_t             vpn_q  [SETS];
  logic [PID_W-1:0] pid_q  [SETS];
  logic             glb_q  [SETS];
  pfn_t             pfn_q  [SETS];
  perm_t            perm_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vpn_q[s]  <= '0;
        pid_q[s]  <= '0;
        glb_q[s]  <= 1'b0;
        pfn_q[s]  <= '0;
        perm_q[s] <= '0;
      end
    end else if (wr_en_i) begin
      vpn_q[wr_set_i]  <= wr_vpn_i;
      pid_q[wr_set_i]  <= wr_pid_i;
      glb_q[wr_set_i]  <= wr_global_i;
      pfn_q[wr_set_i]  <= wr_pfn_i;
      perm_q[wr_set_i] <= wr_perm_i;
    end
  end

  // global entries ignore the PID compare
  assign match_o = (vpn_q[lk_set_i] == lk_vpn_i) &&
                   (glb_q[lk_set_i] || (pid_q[lk_set_i] == lk_pid_i));
  assign pfn_o   = pfn_q[lk_set_i];
  assign perm_o  = perm_q[lk_set_i];
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_ENTRIES = 32,
  parameter int PID_W       = 8,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      vaddr_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [19:0]      wr_vpn_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic             wr_global_i,
  input  logic [19:0]      wr_pfn_i,
  input  logic             wr_rd_i,
  input  logic             wr_wr_i,
  input  logic             wr_ex_i,
  output logic             hit_o,
  output logic [31:0]      paddr_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             ex_o
);
  localparam int SETS  = NUM_ENTRIES / NUM_WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;

  vpn_t             lk_vpn;
  logic [SET_W-1:0] lk_set, wr_set;
  logic [NUM_WAYS-1:0] match, gnt;
  pfn_t             way_pfn  [NUM_WAYS];
  perm_t            way_perm [NUM_WAYS];
  perm_t            wr_perm;
  logic             any_hit;
  pfn_t             sel_pfn;
  perm_t            sel_perm;
  logic             unused_offset;

  assign lk_vpn        = vaddr_i[31:PAGE_SHIFT];
  assign lk_set        = lk_vpn[SET_W-1:0];
  assign wr_set        = wr_vpn_i[SET_W-1:0];
  assign wr_perm       = '{x: wr_ex_i, w: wr_wr_i, r: wr_rd_i};
  assign unused_offset = ^vaddr_i[PAGE_SHIFT-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way #(.SETS(SETS), .PID_W(PID_W)) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && (wr_way_i == WAY_W'(w))),
      .wr_set_i   (wr_set),
      .wr_vpn_i   (wr_vpn_i),
      .wr_pid_i   (wr_pid_i),
      .wr_global_i(wr_global_i),
      .wr_pfn_i   (wr_pfn_i),
      .wr_perm_i  (wr_perm),
      .lk_set_i   (lk_set),
      .lk_vpn_i   (lk_vpn),
      .lk_pid_i   (pid_i),
      .match_o    (match[w]),
      .pfn_o      (way_pfn[w]),
      .perm_o     (way_perm[w])
    );
  end

  tlb_prio_sel #(.N(NUM_WAYS)) u_sel (
    .req_i (match),
    .gnt_o (gnt),
    .any_o (any_hit)
  );

  // one-hot AND-OR mux; zero when nothing is granted
  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      sel_pfn  |= {PFN_W{gnt[w]}} & way_pfn[w];
      sel_perm |= {3{gnt[w]}} & way_perm[w];
    end
  end

  assign hit_o   = any_hit;
  assign paddr_o = {sel_pfn, {PAGE_SHIFT{1'b0}}};
  assign rd_o    = sel_perm.r;
  assign wr_o    = sel_perm.w;
  assign ex_o    = sel_perm.x;

  // R7: a miss leaves every translation output at zero
  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (paddr_o == '0 && !rd_o && !wr_o && !ex_o));

  // R6: the grant is one-hot and no lower way also matches
  p_lowest_way_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && ((match & (gnt - NUM_WAYS'(1)) & ~gnt) == '0 || gnt == '0));

  // R8: a freshly written entry is seen by a matching lookup on the next cycle
  p_write_visible_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!(lk_vpn == $past(wr_vpn_i) && pid_i == $past(wr_pid_i) && !wr_en_i)
                 || hit_o));

  // R3: a global entry just written hits on page match with any PID
  p_global_any_pid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_global_i) |=> (!(lk_vpn == $past(wr_vpn_i) && !wr_en_i) || hit_o));
endmodule

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic [7:0]  pid = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_pid = '0;
  logic        wr_glb = 1'b0;
  logic [19:0] wr_pfn = '0;
  logic        wr_r = 1'b0, wr_w = 1'b0, wr_x = 1'b0;
  logic        hit;
  logic [31:0] paddr;
  logic        rd, wr, ex;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_lookup #(.NUM_WAYS(4), .NUM_ENTRIES(32), .PID_W(8)) u_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .vaddr_i(vaddr), .pid_i(pid),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_vpn_i(wr_vpn), .wr_pid_i(wr_pid),
    .wr_global_i(wr_glb), .wr_pfn_i(wr_pfn), .wr_rd_i(wr_r), .wr_wr_i(wr_w),
    .wr_ex_i(wr_x), .hit_o(hit), .paddr_o(paddr), .rd_o(rd), .wr_o(wr), .ex_o(ex)
  );

  // {vaddr, pid, hit, paddr, perm{x,w,r}}
  localparam logic [75:0] VEC [NUM_VEC] = '{
    {32'h1234_5678, 8'h05, 1'b1, 32'hABCD_E000, 3'b011},
    {32'h1234_5FFF, 8'h05, 1'b1, 32'hABCD_E000, 3'b011},
    {32'h1234_5000, 8'h06, 1'b0, 32'h0000_0000, 3'b000},
    {32'h0001_3ABC, 8'h00, 1'b1, 32'h1111_1000, 3'b100},
    {32'h0001_3000, 8'hFF, 1'b1, 32'h1111_1000, 3'b100},
    {32'h0004_2010, 8'h09, 1'b1, 32'h2222_2000, 3'b001},
    {32'h1034_5678, 8'h05, 1'b0, 32'h0000_0000, 3'b000},
    {32'h0000_0000, 8'h00, 1'b1, 32'h0000_0000, 3'b000},
    {32'h0000_0000, 8'h01, 1'b0, 32'h0000_0000, 3'b000}
  };
  string vec_req [NUM_VEC] = '{"R2", "R1", "R4", "R3", "R3", "R6", "R1", "R9", "R4"};

  task automatic check(input string req, input logic exp_hit,
                       input logic [31:0] exp_pa, input logic [2:0] exp_perm);
    n_tests++;
    if (hit !== exp_hit || paddr !== exp_pa || {ex, wr, rd} !== exp_perm) begin
      n_fail++;
      $display("FAIL %s: got hit=%b pa=%h perm=%b, want hit=%b pa=%h perm=%b",
               req, hit, paddr, {ex, wr, rd}, exp_hit, exp_pa, exp_perm);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] p);
    vaddr = va;
    pid   = p;
    #1;
  endtask

  task automatic load(input logic [1:0] way, input logic [19:0] vpn, input logic [7:0] p,
                      input logic g, input logic [19:0] pfn, input logic [2:0] perm);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_vpn = vpn; wr_pid = p; wr_glb = g; wr_pfn = pfn;
    {wr_x, wr_w, wr_r} = perm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    look(32'h1234_5678, 8'h05);
    check("R9", 1'b0, 32'h0, 3'b000);   // cleared table misses real page
    look(32'h0000_0ABC, 8'h00);
    check("R9", 1'b1, 32'h0, 3'b000);   // cleared entry matches page 0 / PID 0
    rst_n = 1'b1;

    load(2'd1, 20'h12345, 8'h05, 1'b0, 20'hABCDE, 3'b011);
    load(2'd0, 20'h00013, 8'h07, 1'b1, 20'h11111, 3'b100);
    load(2'd2, 20'h00042, 8'h09, 1'b0, 20'h22222, 3'b001);
    load(2'd3, 20'h00042, 8'h09, 1'b0, 20'h33333, 3'b010);

    for (int i = 0; i < NUM_VEC; i++) begin
      @(negedge clk);
      look(VEC[i][75:44], VEC[i][43:36]);
      check(vec_req[i], VEC[i][35], VEC[i][34:3], VEC[i][2:0]);
    end

    // R5: full-width frame and every permission
    load(2'd0, 20'hFEDCB, 8'h22, 1'b0, 20'hFFFFF, 3'b111);
    look(32'hFEDC_B123, 8'h22);
    check("R5", 1'b1, 32'hFFFF_F000, 3'b111);

    // R6: global entry in way 1 now outranks ways 2 and 3
    load(2'd1, 20'h00042, 8'h00, 1'b1, 20'h44444, 3'b111);
    look(32'h0004_2000, 8'h09);
    check("R6", 1'b1, 32'h4444_4000, 3'b111);
    // R8: way 1 set 5 untouched by the set 2 write
    look(32'h1234_5000, 8'h05);
    check("R8", 1'b1, 32'hABCD_E000, 3'b011);

    // R10: overwrite way 1 set 5
    load(2'd1, 20'h12345, 8'h05, 1'b0, 20'h55555, 3'b100);
    look(32'h1234_5000, 8'h05);
    check("R10", 1'b1, 32'h5555_5000, 3'b100);

    // R8: invisible before the edge, visible after
    @(negedge clk);
    wr_en = 1'b1; wr_way = 2'd0; wr_vpn = 20'h77777; wr_pid = 8'h03; wr_glb = 1'b0;
    wr_pfn = 20'h0BEEF; {wr_x, wr_w, wr_r} = 3'b010;
    look(32'h7777_7000, 8'h03);
    check("R8", 1'b0, 32'h0, 3'b000);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R8", 1'b1, 32'h0BEE_F000, 3'b010);

    // R9: reset wipes loaded entries
    @(negedge clk);
    rst_n = 1'b0;
    look(32'h1234_5000, 8'h05);
    check("R9", 1'b0, 32'h0, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    look(32'h0001_3000, 8'h07);
    check("R9", 1'b0, 32'h0, 3'b000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule